// File: doc/BRIEF.md
# Converter Result Holding Register with Read-Order Interlock

This block holds the latest 10-bit result from an analog-to-digital converter and presents it to a processor bus as two 8-bit read-only bytes at two consecutive addresses. A mode input selects one of two layouts. In the truncated layout, the eight upper result bits appear in the low byte and the high byte reads as zero. In the right-justified layout, the two upper result bits appear in the bottom of the high byte and the eight lower bits appear in the low byte.

In the right-justified layout, software reads the high byte first and then the low byte. A read-order interlock keeps the two halves consistent. A two-state machine controls it. The state `ST_OPEN` accepts new results. The state `ST_LOCKED` drops every conversion strobe. There are three transitions. `T_LOCK` (ST_OPEN to ST_LOCKED) is taken on a high-byte read in the right-justified layout, when the mode has not just changed. `T_RELEASE` (ST_LOCKED to ST_OPEN) is taken on a low-byte read. `T_MODE_CLEAR` (ST_LOCKED to ST_OPEN) is taken in any cycle in which the mode input differs from its value in the previous cycle. The truncated layout never enters `ST_LOCKED`. The converter, channel selection, other control registers and interrupts lie outside this block.

The read port is combinational: `rd_data` reflects `rd_addr` in the same cycle as `rd_en`. A result accepted at a clock edge is visible from the next cycle on.

Top module: `adc_result_holder`

## Requirements
- R1: After reset, both bytes read 0x00 and the interlock is in ST_OPEN.
- R2: The high byte is at address BASE_ADDR (default 6) and the low byte is at BASE_ADDR+1. Any other address, or `rd_en` low, gives `rd_data` = 0x00.
- R3: In the truncated layout (`mode_rj`=0), the low byte equals result bits 9:2 and the high byte reads 0x00.
- R4: In the truncated layout, every strobe is accepted whatever reads occur, so reads in any order never block an update.
- R5: In the right-justified layout (`mode_rj`=1), high-byte bits 1:0 equal result bits 9:8, high-byte bits 7:2 read 0, and the low byte equals result bits 7:0.
- R6: In the right-justified layout, in ST_OPEN, a strobe with no high-byte read in the same cycle is captured and becomes readable in the next cycle.
- R7: In the right-justified layout, a high-byte read moves ST_OPEN to ST_LOCKED (T_LOCK). A strobe in that same cycle, or in any cycle while ST_LOCKED, is dropped.
- R8: A low-byte read while ST_LOCKED returns to ST_OPEN (T_RELEASE). A strobe in that same cycle is dropped, and the next strobe after it is captured.
- R9: A change of `mode_rj` from one cycle to the next returns the interlock to ST_OPEN (T_MODE_CLEAR).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rj | input | 1 | 1 = right-justified layout, 0 = truncated layout |
| conv_done | input | 1 | Conversion-complete strobe |
| conv_data | input | 10 | Conversion result, valid with the strobe |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (4) | Read address |
| rd_data | output | 8 | Read data, combinational |

## Verification
A state machine stuck in ST_LOCKED shows up as a byte that does not change after the next strobe. A missed lock shows up as a low byte that no longer matches the high byte read just before it. Both become visible on the first read one cycle after the strobe. A wrong layout or address decode shows up at once, on the read in which it occurs. Random reads and strobes, with occasional mode flips, are compared against a bench model on every cycle. Directed sequences cover same-cycle strobe-and-read collisions.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
    typedef enum logic [0:0] {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/adc_res_decode.sv
module adc_res_decode #(
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 6
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              hi_rd,
    output logic              lo_rd
);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR + 1);

    always_comb begin
        hi_rd = rd_en && (rd_addr == HI_ADDR);
        lo_rd = rd_en && (rd_addr == LO_ADDR);
    end
endmodule

// File: rtl/adc_res_map.sv
module adc_res_map #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              mode_rj,
    input  logic [RES_W-1:0]  res,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [BYTE_W-1:0] lo_byte
);
    localparam int UPPER_W = RES_W - BYTE_W;

    always_comb begin
        if (mode_rj) begin
            hi_byte = {{(BYTE_W-UPPER_W){1'b0}}, res[RES_W-1:BYTE_W]};
            lo_byte = res[BYTE_W-1:0];
        end else begin
            hi_byte = '0;
            lo_byte = res[RES_W-1:UPPER_W];
        end
    end
endmodule

// File: rtl/adc_res_lock_fsm.sv
module adc_res_lock_fsm
    import adc_res_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_rj,
    input  logic hi_rd,
    input  logic lo_rd,
    input  logic conv_done,
    output logic accept
);
    lock_state_t state, state_nx;
    logic        mode_q;
    logic        mode_chg;

    assign mode_chg = (mode_rj != mode_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: begin
                if (!mode_chg && mode_rj && hi_rd)
                    state_nx = ST_LOCKED;            // T_LOCK
            end
            ST_LOCKED: begin
                if (mode_chg)
                    state_nx = ST_OPEN;              // T_MODE_CLEAR
                else if (lo_rd)
                    state_nx = ST_OPEN;              // T_RELEASE
            end
            default: state_nx = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OPEN;
            mode_q <= 1'b0;
        end else begin
            state  <= state_nx;
            mode_q <= mode_rj;
        end
    end

    always_comb begin
        accept = 1'b0;
        unique case (state)
            ST_OPEN:   accept = conv_done && !(mode_rj && hi_rd);
            ST_LOCKED: accept = conv_done && !mode_rj;
            default:   accept = 1'b0;
        endcase
    end

    p_lock_needs_rj_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |-> mode_q);
    p_hi_read_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rj && mode_q && hi_rd) |=> (state == ST_LOCKED));
    p_drop_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rj && state == ST_LOCKED) |-> !accept);
    p_lo_read_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && lo_rd) |=> (state == ST_OPEN));
    p_mode_change_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rj != mode_q) |=> (state == ST_OPEN));
endmodule

// File: rtl/adc_result_holder.sv
module adc_result_holder #(
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 6,
    parameter int RES_W     = 10,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_rj,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic              hi_rd, lo_rd, accept;
    logic [RES_W-1:0]  res;
    logic [BYTE_W-1:0] hi_byte, lo_byte;

    adc_res_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_decode (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .hi_rd   (hi_rd),
        .lo_rd   (lo_rd)
    );

    adc_res_lock_fsm i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_rj   (mode_rj),
        .hi_rd     (hi_rd),
        .lo_rd     (lo_rd),
        .conv_done (conv_done),
        .accept    (accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res <= '0;
        else if (accept)
            res <= conv_data;
    end

    adc_res_map #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_map (
        .mode_rj (mode_rj),
        .res     (res),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte)
    );

    always_comb begin
        if (hi_rd)
            rd_data = hi_byte;
        else if (lo_rd)
            rd_data = lo_byte;
        else
            rd_data = '0;
    end

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (res == $past(conv_data)));
    p_trunc_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !mode_rj) |=> (res == $past(conv_data)));
    p_trunc_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd && !mode_rj) |-> (rd_data == '0));
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
endmodule

// File: tb/test_adc_result_holder.sv
module test_adc_result_holder;
    localparam int PERIOD = 10;
    localparam int AW     = 4;
    localparam int BASE   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_rj = 1'b0;
    logic          conv_done = 1'b0;
    logic [9:0]    conv_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model
    logic [9:0] m_res = '0;
    bit         m_lock = 0;
    bit         m_mode_q = 0;

    always #(PERIOD/2) clk = ~clk;

    adc_result_holder #(.ADDR_W(AW), .BASE_ADDR(BASE)) i_adc_result_holder (
        .clk(clk), .rst_n(rst_n), .mode_rj(mode_rj), .conv_done(conv_done),
        .conv_data(conv_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_read(logic re, logic [AW-1:0] a, logic m, logic [9:0] r);
        if (!re) return 8'h00;
        if (a == AW'(BASE))     return m ? {6'b0, r[9:8]} : 8'h00;
        if (a == AW'(BASE + 1)) return m ? r[7:0] : r[9:2];
        return 8'h00;
    endfunction

    function automatic string auto_tag(logic re, logic [AW-1:0] a, logic m);
        if (!re || (a != AW'(BASE) && a != AW'(BASE + 1))) return "R2";
        return m ? "R5" : "R3";
    endfunction

    task automatic check(logic [7:0] exp, string tag);
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected=%h at %0t", tag, rd_data, exp, $time);
        end
    endtask

    // drive one cycle, check read data, then advance the model at the edge
    task automatic step(logic cd, logic [9:0] d, logic re, logic [AW-1:0] a, logic m, string tag);
        bit hi, lo, acc;
        @(negedge clk);
        conv_done = cd; conv_data = d; rd_en = re; rd_addr = a; mode_rj = m;
        #1;
        check(exp_read(re, a, m, m_res), (tag == "") ? auto_tag(re, a, m) : tag);
        hi  = re && (a == AW'(BASE));
        lo  = re && (a == AW'(BASE + 1));
        acc = cd && !(m && (m_lock || hi));
        @(posedge clk);
        if (acc) m_res = d;
        if (m != m_mode_q)         m_lock = 0;
        else if (m && hi)          m_lock = 1;
        else if (lo)               m_lock = 0;
        m_mode_q = m;
    endtask

    localparam logic [AW-1:0] HI = AW'(BASE);
    localparam logic [AW-1:0] LO = AW'(BASE + 1);

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        rd_en = 1; rd_addr = HI; #1; check(8'h00, "R1");
        rd_addr = LO; #1; check(8'h00, "R1");
        rst_n = 1'b1;

        // R3/R4 truncated layout, reads do not block
        step(1, 10'h3A5, 1, HI, 0, "R4");
        step(0, 10'h000, 1, LO, 0, "R3");          // 3A5>>2 = E9
        step(1, 10'h155, 1, HI, 0, "R3");
        step(0, 10'h000, 1, LO, 0, "R4");          // 155>>2 = 55
        step(0, 10'h000, 1, 4'h0, 0, "R2");
        // switch to right-justified
        step(0, 10'h000, 0, HI, 1, "R9");
        step(1, 10'h2C3, 0, HI, 1, "R6");
        step(0, 10'h000, 1, HI, 1, "R5");          // reads 02, locks
        step(1, 10'h111, 1, LO, 1, "R7");          // locked, dropped; low C3
        step(0, 10'h000, 1, LO, 1, "R8");          // still C3
        step(1, 10'h0F0, 0, HI, 1, "R8");          // accepted
        step(0, 10'h000, 1, LO, 1, "R8");          // F0
        // high read with strobe in same cycle: dropped
        step(1, 10'h3FF, 1, HI, 1, "R7");          // reads 00
        step(0, 10'h000, 1, LO, 1, "R7");          // still F0, unlocks
        // lock, then same-cycle strobe and low read
        step(0, 10'h000, 1, HI, 1, "R7");
        step(1, 10'h2AA, 1, LO, 1, "R8");          // dropped
        step(0, 10'h000, 1, LO, 1, "R8");          // F0
        step(1, 10'h1BC, 0, LO, 1, "R8");
        step(0, 10'h000, 1, HI, 1, "R5");          // 01
        // mode change clears lock (state locked now)
        step(0, 10'h000, 0, HI, 0, "R9");
        step(0, 10'h000, 0, HI, 1, "R9");
        step(1, 10'h222, 1, HI, 1, "R9");          // open: not locked, but hi read drops
        step(1, 10'h333, 1, HI, 1, "R7");          // locked now, dropped
        step(0, 10'h000, 1, LO, 0, "R9");          // mode change; trunc of 1BC = 6F
        step(1, 10'h333, 0, HI, 1, "R9");          // open after change
        step(0, 10'h000, 1, LO, 1, "R9");          // 33

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic          m;
            int            sel;
            sel = $urandom_range(0, 9);
            a = (sel < 4) ? HI : (sel < 8) ? LO : AW'($urandom_range(0, (1 << AW) - 1));
            m = ($urandom_range(0, 31) == 0) ? ~mode_rj : mode_rj;
            step($urandom_range(0, 2) == 0, 10'($urandom), $urandom_range(0, 3) != 0, a, m, "");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule